// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the bit-level engine of an I2C master. A controller hands it one command at a time: open a transfer with a START condition, close it with a STOP condition, shift out one byte, or shift in one byte. The engine drives both bus lines as open-drain pins. Each output is an enable that pulls its line low, and the data line is read back through a synchronizer. After a write it reports whether the target acknowledged the byte. After a read it returns the byte it collected and has already sent its own acknowledge bit. The last-byte flag decides whether that bit is ACK or NACK.

Every phase of the bus waveform lasts a fixed number of system clocks. By default each count is worked out from the clock frequency parameter so that it meets the standard-mode minimum times. A STOP can also follow a byte on its own, without a separate command: a write appends one when its stop flag is set, and a read appends one only when both its stop flag and its last flag are set. This saves the controller a command round-trip at the end of a transfer.

Top module: `i2c_byte_master`

## Requirements
- R1: While reset is asserted and right after it, scl_drive_o, sda_drive_o, busy_o and done_o are all 0 (both lines released).
- R2: A command is taken only on a cycle where cmd_valid_i is 1 and busy_o is 0. busy_o is 1 from the next cycle until the last phase of the command (including any automatic STOP) ends. In the following cycle done_o is 1 for exactly one cycle and busy_o is 0. A cmd_valid_i pulse while busy_o is 1 has no effect on the lines or on the running command.
- R3: The cmd_i encoding is 0 = START, 1 = STOP, 2 = WRITE, 3 = READ. wdata_i, stop_i and last_i are captured in the accepting cycle.
- R4: START releases both lines for T_BUF cycles. It then drives SDA low with SCL released for T_HDSTA cycles. It then drives both low for T_LOW cycles.
- R5: STOP drives both low for T_SUDAT cycles. It then releases SCL with SDA low for T_SUSTO cycles. It then releases both for one cycle before finishing.
- R6: A write sends wdata_i MSB first. For each bit, sda_drive_o is the inverse of the bit, held through three sub-phases: SCL low for T_SUDAT, SCL released for T_HIGH, SCL low for T_LOW.
- R7: After the eighth written bit, SDA is released for the acknowledge slot: SCL low for T_LOW, released for T_HIGH, low for T_LOW. ack_o becomes 1 when the synchronized SDA is low in the last released cycle, and 0 otherwise.
- R8: A read releases SDA. It holds SCL low for T_SUDAT, then runs eight clocks of SCL released for T_HIGH followed by SCL low for T_LOW. At the end of each released period it shifts the synchronized SDA into rdata_o at bit 0, so the first bit received ends in bit 7.
- R9: After a read, the engine drives its acknowledge bit over three sub-phases: SCL low for T_SUDAT, released for T_HIGH, low for T_LOW. SDA is driven low (ACK) when last_i was 0 and released (NACK) when last_i was 1. SDA is then released with SCL low for T_LOW.
- R10: A write with stop_i set appends the R5 STOP sequence, whatever the acknowledge outcome. A read appends it only when both stop_i and last_i are set.
- R11: sda_drive_o changes while SCL stays released only inside a START or a STOP sequence.
- R12: The default timing counts are ceil(min_ns × CLK_HZ / 1e9), with a minimum of 1. At 10 MHz this gives T_BUF 47, T_HDSTA 40, T_LOW 47, T_HIGH 40, T_SUSTO 40 and T_SUDAT 3.
- R13: Between commands, scl_drive_o and sda_drive_o keep the levels of the last phase, and rdata_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 2 | Command code (R3) |
| wdata_i | input | 8 | Byte to write |
| stop_i | input | 1 | Append STOP after the byte |
| last_i | input | 1 | Read is the last byte (NACK) |
| sda_i | input | 1 | Sensed SDA line level |
| scl_drive_o | output | 1 | Pull SCL low when 1 |
| sda_drive_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ack_o | output | 1 | Last written byte was acknowledged |
| rdata_o | output | 8 | Last byte read |

## Verification
The checker watches, on every cycle, the command handshake (acceptance, the single done pulse and the end of busy), the rule that SDA moves under a released SCL only during START or STOP, the minimum SCL high time, and the stability of read data between commands. The exact length of every phase, the bit order, the acknowledge polarity and the choice of when to append a STOP only show up in the bench. Its cycle-accurate reference model replays each command, with a responding target on the bus, and is compared with the lines on every clock.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } cmd_e;

  typedef enum logic [4:0] {
    PH_IDLE,
    PH_ST_BUF, PH_ST_HOLD, PH_ST_LOW,
    PH_SP_PRE, PH_SP_SETUP, PH_SP_REL,
    PH_W_SET, PH_W_HIGH, PH_W_LOW,
    PH_WA_LOW, PH_WA_HIGH, PH_WA_TAIL,
    PH_R_PRE, PH_R_HIGH, PH_R_LOW,
    PH_RA_SET, PH_RA_HIGH, PH_RA_LOW, PH_RA_REL
  } phase_e;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic int unsigned ns_to_cyc(input longint unsigned hz, input longint unsigned ns);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 64'd1) c = 64'd1;
    return c[31:0];
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/i2c_bm_timer.sv
module i2c_bm_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - W'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master import i2c_bm_pkg::*; #(
  parameter int unsigned CLK_HZ      = 10_000_000,
  parameter int unsigned T_BUF_CYC   = ns_to_cyc(CLK_HZ, 4700),
  parameter int unsigned T_HDSTA_CYC = ns_to_cyc(CLK_HZ, 4000),
  parameter int unsigned T_LOW_CYC   = ns_to_cyc(CLK_HZ, 4700),
  parameter int unsigned T_HIGH_CYC  = ns_to_cyc(CLK_HZ, 4000),
  parameter int unsigned T_SUSTO_CYC = ns_to_cyc(CLK_HZ, 4000),
  parameter int unsigned T_SUDAT_CYC = ns_to_cyc(CLK_HZ, 250),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic [7:0] wdata_i,
  input  logic       stop_i,
  input  logic       last_i,
  input  logic       sda_i,
  output logic       scl_drive_o,
  output logic       sda_drive_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       ack_o,
  output logic [7:0] rdata_o
);
  localparam int unsigned T_MAX = max2(max2(max2(T_BUF_CYC, T_HDSTA_CYC), max2(T_LOW_CYC, T_HIGH_CYC)),
                                       max2(T_SUSTO_CYC, T_SUDAT_CYC));
  localparam int CW = $clog2(T_MAX + 1);

  phase_e      phase_q, phase_d;
  logic [7:0]  tx_q, rx_q;
  logic [2:0]  bit_q;
  logic        stop_q, last_q, ack_q, done_q;
  logic        scl_q, sda_q, scl_d, sda_d;
  logic        sda_s, tmr_zero, accept, step, load, wbit;
  logic [CW-1:0] len_d;

  i2c_bm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  i2c_bm_timer #(.W(CW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .len_i(len_d), .zero_o(tmr_zero)
  );

  assign accept = cmd_valid_i && (phase_q == PH_IDLE);
  assign step   = (phase_q != PH_IDLE) && tmr_zero;
  assign load   = accept || (step && (phase_d != PH_IDLE));
  // data bit presented during the upcoming write sub-phase
  assign wbit   = accept ? wdata_i[7] : ((phase_q == PH_W_LOW) ? tx_q[6] : tx_q[7]);

  always_comb begin
    phase_d = phase_q;
    if (accept) begin
      unique case (cmd_e'(cmd_i))
        CMD_START: phase_d = PH_ST_BUF;
        CMD_STOP:  phase_d = PH_SP_PRE;
        CMD_WRITE: phase_d = PH_W_SET;
        default:   phase_d = PH_R_PRE;
      endcase
    end else if (step) begin
      unique case (phase_q)
        PH_ST_BUF:   phase_d = PH_ST_HOLD;
        PH_ST_HOLD:  phase_d = PH_ST_LOW;
        PH_ST_LOW:   phase_d = PH_IDLE;
        PH_SP_PRE:   phase_d = PH_SP_SETUP;
        PH_SP_SETUP: phase_d = PH_SP_REL;
        PH_SP_REL:   phase_d = PH_IDLE;
        PH_W_SET:    phase_d = PH_W_HIGH;
        PH_W_HIGH:   phase_d = PH_W_LOW;
        PH_W_LOW:    phase_d = (bit_q == 3'd0) ? PH_WA_LOW : PH_W_SET;
        PH_WA_LOW:   phase_d = PH_WA_HIGH;
        PH_WA_HIGH:  phase_d = PH_WA_TAIL;
        PH_WA_TAIL:  phase_d = stop_q ? PH_SP_PRE : PH_IDLE;
        PH_R_PRE:    phase_d = PH_R_HIGH;
        PH_R_HIGH:   phase_d = PH_R_LOW;
        PH_R_LOW:    phase_d = (bit_q == 3'd0) ? PH_RA_SET : PH_R_HIGH;
        PH_RA_SET:   phase_d = PH_RA_HIGH;
        PH_RA_HIGH:  phase_d = PH_RA_LOW;
        PH_RA_LOW:   phase_d = PH_RA_REL;
        PH_RA_REL:   phase_d = (stop_q && last_q) ? PH_SP_PRE : PH_IDLE;
        default:     phase_d = PH_IDLE;
      endcase
    end
  end

  // line levels (1 = pull low) and length of the phase being entered
  always_comb begin
    scl_d = scl_q;
    sda_d = sda_q;
    len_d = CW'(1);
    unique case (phase_d)
      PH_ST_BUF:   begin scl_d = 1'b0; sda_d = 1'b0;    len_d = CW'(T_BUF_CYC);   end
      PH_ST_HOLD:  begin scl_d = 1'b0; sda_d = 1'b1;    len_d = CW'(T_HDSTA_CYC); end
      PH_ST_LOW:   begin scl_d = 1'b1; sda_d = 1'b1;    len_d = CW'(T_LOW_CYC);   end
      PH_SP_PRE:   begin scl_d = 1'b1; sda_d = 1'b1;    len_d = CW'(T_SUDAT_CYC); end
      PH_SP_SETUP: begin scl_d = 1'b0; sda_d = 1'b1;    len_d = CW'(T_SUSTO_CYC); end
      PH_SP_REL:   begin scl_d = 1'b0; sda_d = 1'b0;    len_d = CW'(1);           end
      PH_W_SET:    begin scl_d = 1'b1; sda_d = ~wbit;   len_d = CW'(T_SUDAT_CYC); end
      PH_W_HIGH:   begin scl_d = 1'b0; sda_d = ~wbit;   len_d = CW'(T_HIGH_CYC);  end
      PH_W_LOW:    begin scl_d = 1'b1; sda_d = ~wbit;   len_d = CW'(T_LOW_CYC);   end
      PH_WA_LOW:   begin scl_d = 1'b1; sda_d = 1'b0;    len_d = CW'(T_LOW_CYC);   end
      PH_WA_HIGH:  begin scl_d = 1'b0; sda_d = 1'b0;    len_d = CW'(T_HIGH_CYC);  end
      PH_WA_TAIL:  begin scl_d = 1'b1; sda_d = 1'b0;    len_d = CW'(T_LOW_CYC);   end
      PH_R_PRE:    begin scl_d = 1'b1; sda_d = 1'b0;    len_d = CW'(T_SUDAT_CYC); end
      PH_R_HIGH:   begin scl_d = 1'b0; sda_d = 1'b0;    len_d = CW'(T_HIGH_CYC);  end
      PH_R_LOW:    begin scl_d = 1'b1; sda_d = 1'b0;    len_d = CW'(T_LOW_CYC);   end
      PH_RA_SET:   begin scl_d = 1'b1; sda_d = ~last_q; len_d = CW'(T_SUDAT_CYC); end
      PH_RA_HIGH:  begin scl_d = 1'b0; sda_d = ~last_q; len_d = CW'(T_HIGH_CYC);  end
      PH_RA_LOW:   begin scl_d = 1'b1; sda_d = ~last_q; len_d = CW'(T_LOW_CYC);   end
      PH_RA_REL:   begin scl_d = 1'b1; sda_d = 1'b0;    len_d = CW'(T_LOW_CYC);   end
      default:     ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      stop_q  <= 1'b0;
      last_q  <= 1'b0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= step && (phase_d == PH_IDLE);
      if (load) begin
        scl_q <= scl_d;
        sda_q <= sda_d;
      end
      if (accept) begin
        tx_q   <= wdata_i;
        bit_q  <= 3'd7;
        stop_q <= stop_i;
        last_q <= last_i;
      end else if (step) begin
        if (phase_q == PH_W_LOW) tx_q <= {tx_q[6:0], 1'b0};
        if (phase_q == PH_W_LOW || phase_q == PH_R_LOW) bit_q <= bit_q - 3'd1;
        if (phase_q == PH_R_HIGH) rx_q <= {rx_q[6:0], sda_s};
        if (phase_q == PH_WA_HIGH) ack_q <= ~sda_s;
      end
    end
  end

  assign scl_drive_o = scl_q;
  assign sda_drive_o = sda_q;
  assign busy_o      = (phase_q != PH_IDLE);
  assign done_o      = done_q;
  assign ack_o       = ack_q;
  assign rdata_o     = rx_q;
endmodule

// File: rtl/i2c_bm_chk.sv
module i2c_bm_chk #(
  parameter int unsigned T_HIGH_CYC = 40
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [1:0] cmd_i,
  input logic       stop_i,
  input logic       scl_drive_o,
  input logic       sda_drive_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] rdata_o
);
  logic        ctl_ok_q;
  int unsigned hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_ok_q <= 1'b0;
      hi_cnt_q <= 0;
    end else begin
      if (cmd_valid_i && !busy_o)
        ctl_ok_q <= (cmd_i == 2'd0) || (cmd_i == 2'd1) || stop_i;
      if (scl_drive_o)                hi_cnt_q <= 0;
      else if (hi_cnt_q < T_HIGH_CYC) hi_cnt_q <= hi_cnt_q + 1;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o) |=> busy_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o ##1 !done_o));
  // R2
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R11
  sda_under_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_drive_o && !$past(scl_drive_o) && (sda_drive_o != $past(sda_drive_o))) |-> ctl_ok_q);
  // R6
  scl_high_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_drive_o) |-> (hi_cnt_q >= T_HIGH_CYC));
  // R13
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(rdata_o));
endmodule

bind i2c_byte_master i2c_bm_chk #(.T_HIGH_CYC(T_HIGH_CYC)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
  .stop_i(stop_i), .scl_drive_o(scl_drive_o), .sda_drive_o(sda_drive_o),
  .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
);

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned HZ = 10_000_000;

  function automatic int cyc(input longint unsigned ns);
    longint unsigned t;
    t = ns * HZ;
    t = t / 64'd1_000_000_000 + ((t % 64'd1_000_000_000) != 0 ? 64'd1 : 64'd0);
    return (t == 0) ? 1 : int'(t);
  endfunction

  localparam int TBUF = cyc(4700), THD = cyc(4000), TLO = cyc(4700);
  localparam int THI = cyc(4000), TSS = cyc(4000), TSU = cyc(250);

  logic clk = 1'b0, rst_n = 1'b1;
  logic cmd_valid = 1'b0, stop = 1'b0, last = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic slv = 1'b1, sda_line;
  logic scl_drive, sda_drive, busy, done, ack;
  logic [7:0] rdata;

  assign sda_line = slv & ~sda_drive;

  i2c_byte_master #(.CLK_HZ(32'd10_000_000)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .wdata_i(wdata), .stop_i(stop), .last_i(last), .sda_i(sda_line),
    .scl_drive_o(scl_drive), .sda_drive_o(sda_drive), .busy_o(busy),
    .done_o(done), .ack_o(ack), .rdata_o(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      if (n_fail < 30) $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: queue of line segments
  typedef struct { bit scl; bit sda; int len; bit slv; } seg_t;
  seg_t q[$];
  bit m_busy = 0, m_done = 0, m_scl = 0, m_sda = 0, m_slv = 1;
  int m_cnt = 0;
  bit slv_ack = 1;
  logic [7:0] slv_byte = 8'h00;

  function automatic void push(input bit s, input bit d, input int n, input bit v);
    seg_t e;
    e.scl = s; e.sda = d; e.len = n; e.slv = v;
    q.push_back(e);
  endfunction

  function automatic void add_stop();
    push(1, 1, TSU, 1); push(0, 1, TSS, 1); push(0, 0, 1, 1);
  endfunction

  function automatic void build(input logic [1:0] c, input logic [7:0] d, input bit st, input bit la);
    case (c)
      2'd0: begin push(0, 0, TBUF, 1); push(0, 1, THD, 1); push(1, 1, TLO, 1); end
      2'd1: add_stop();
      2'd2: begin
        for (int i = 7; i >= 0; i--) begin
          push(1, ~d[i], TSU, 1); push(0, ~d[i], THI, 1); push(1, ~d[i], TLO, 1);
        end
        push(1, 0, TLO, ~slv_ack); push(0, 0, THI, ~slv_ack); push(1, 0, TLO, 1);
        if (st) add_stop();
      end
      default: begin
        push(1, 0, TSU, slv_byte[7]);
        for (int i = 7; i >= 0; i--) begin
          push(0, 0, THI, slv_byte[i]);
          push(1, 0, TLO, (i > 0) ? slv_byte[(i > 0) ? i-1 : 0] : 1'b1);
        end
        push(1, ~la, TSU, 1); push(0, ~la, THI, 1); push(1, ~la, TLO, 1); push(1, 0, TLO, 1);
        if (st && la) add_stop();
      end
    endcase
  endfunction

  function automatic void pop();
    seg_t e;
    e = q.pop_front();
    m_scl = e.scl; m_sda = e.sda; m_cnt = e.len; m_slv = e.slv; m_busy = 1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, {scl_drive, sda_drive, busy, done}, {m_scl, m_sda, m_busy, m_done});
      slv = m_busy ? m_slv : 1'b1;
      m_done = 0;
      if (!m_busy) begin
        if (cmd_valid) begin build(cmd, wdata, stop, last); pop(); end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          if (q.size() > 0) pop();
          else begin m_busy = 0; m_done = 1; end
        end
      end
    end
  end

  task automatic run_cmd(input logic [1:0] c, input logic [7:0] d, input bit st, input bit la,
                         input int poke_at);
    @(posedge clk); #1;
    cmd_valid = 1; cmd = c; wdata = d; stop = st; last = la;
    @(posedge clk); #1;
    cmd_valid = 0;
    if (poke_at > 0) begin
      repeat (poke_at) @(posedge clk);
      #1; cmd_valid = 1; cmd = 2'd1;
      @(posedge clk); #1; cmd_valid = 0;
    end
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d, input bit a, input bit st, input int poke);
    slv_ack = a;
    run_cmd(2'd2, d, st, 1'b0, poke);
    check("R7 ack_o", ack, a);
  endtask

  task automatic do_read(input logic [7:0] d, input bit la, input bit st);
    slv_byte = d;
    run_cmd(2'd3, 8'h00, st, la, 0);
    check("R8 rdata_o", rdata, d);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: released lines and idle handshake under reset
    check("R1 reset", {scl_drive, sda_drive, busy, done}, 4'b0000);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {scl_drive, sda_drive, busy, done}, 4'b0000);
    // R12: counts at 10 MHz
    check("R12 counts", {TBUF, THD, TLO, THI, TSS, TSU} == {32'd47, 32'd40, 32'd47, 32'd40, 32'd40, 32'd3}, 1);

    tag = "R3 R4 START";
    run_cmd(2'd0, 8'h00, 0, 0, 0);
    tag = "R6 R7 write acked";
    do_write(8'hA5, 1, 0, 0);
    tag = "R13 idle hold";
    repeat (20) @(negedge clk);
    check("R13 idle levels", {scl_drive, sda_drive, busy}, 3'b100);
    tag = "R8 R9 read ack";
    do_read(8'h5A, 0, 0);
    tag = "R9 R10 read last no stop";
    do_read(8'hC3, 1, 0);
    check("R10 no stop", {scl_drive, sda_drive}, 2'b10);
    tag = "R5 STOP";
    run_cmd(2'd1, 8'h00, 0, 0, 0);
    check("R5 lines free", {scl_drive, sda_drive}, 2'b00);

    tag = "R4 R11 START";
    run_cmd(2'd0, 8'h00, 0, 0, 0);
    tag = "R2 R7 R10 write nack stop busy-poke";
    do_write(8'h3C, 0, 1, 100);
    check("R10 stop after write", {scl_drive, sda_drive}, 2'b00);

    tag = "R4 START";
    run_cmd(2'd0, 8'h00, 0, 0, 0);
    tag = "R6 write acked";
    do_write(8'h81, 1, 0, 0);
    tag = "R9 R10 read stop not last";
    do_read(8'h96, 0, 1);
    check("R10 no stop without last", {scl_drive, sda_drive}, 2'b10);
    tag = "R8 R9 R10 read last stop";
    do_read(8'h0F, 1, 1);
    check("R10 stop after last read", {scl_drive, sda_drive}, 2'b00);
    repeat (10) @(negedge clk);
    check("R13 rdata held", rdata, 8'h0F);
    finish_run();
  end
endmodule